// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block holds 1024 sixteen-bit words in front of a slow main-memory port that takes 22-bit byte addresses. A processor issues one word read or write at a time. Reads that find their word in the cache return one cycle later. Reads that miss fetch the word from memory, return it and keep a copy. Writes always go to memory. A write changes a cached copy only when that copy is already present.

Storage is two-way set associative, with 512 sets. On a miss, the way to refill is an empty way if one exists, or otherwise the low bit of a free-running LFSR. Each entry carries a parity bit over its tag and one parity bit for each data byte, and these are checked on every read. A bad entry is dropped, reported on a one-cycle error pulse and fetched again from memory, so software never sees the fault.

Two configuration inputs provide a degraded mode. One makes every access miss. The other switches off either way individually. A test input inverts the stored data parity, so the recovery path can be exercised.

Top module: `cache2w`

## Requirements
- R1: The byte address splits into set index = addr[9:1] and tag = addr[21:10]. addr[0] is ignored. Memory requests carry the request address with bit 0 cleared.
- R2: A read hit raises resp_valid with the cached word exactly one cycle after acceptance and issues no memory request.
- R3: A read miss issues one memory read. resp_rdata equals mem_rdata one cycle after mem_ack. The word is kept, so a following read of it hits.
- R4: A refill uses an enabled empty way first (way 0 before way 1). Only when both ways are valid does the LFSR low bit choose. Two tags read into an empty set therefore both stay resident.
- R5: Every write issues exactly one memory write with the request address (bit 0 cleared) and data. resp_valid follows one cycle after mem_ack.
- R6: A write miss does not allocate, so a later read of that word misses. A write hit updates the cached word at acceptance, so a later read hits with the new value.
- R7: On a read, a valid tag-matching entry whose stored parity disagrees with its contents is treated as a miss. It is invalidated, par_err pulses for exactly one cycle, and the correct word is fetched from memory and refilled.
- R8: While cfg_bypass is 1, every read misses and nothing is refilled. A write that matches a cached entry invalidates it, so data stays correct after bypass ends.
- R9: A way whose cfg_way_off bit is 1 (bit 0 for way 0, bit 1 for way 1) is never hit or refilled. With one way off, two tags of one set evict each other.
- R10: After reset all entries are invalid, req_ready is 1, and resp_valid, par_err and mem_req are 0.
- R11: When flip_par is 1 at acceptance of a refilling read or a write hit, the stored low-byte parity bit is inverted, so the next read of that word detects an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, valid with resp_valid |
| cfg_bypass | input | 1 | Force all accesses to miss |
| cfg_way_off | input | 2 | Per-way disable |
| flip_par | input | 1 | Store inverted data parity (test) |
| par_err | output | 1 | One-cycle parity error pulse |
| mem_req | output | 1 | Memory transaction pending |
| mem_write | output | 1 | Pending transaction is a write |
| mem_addr | output | 22 | Memory byte address, bit 0 cleared |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completes transaction |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |

## Verification
The bench uses the default parameters: 22-bit addresses, 16-bit words and 512 sets. A random phase confines traffic to four sets and four tags, so both ways fill, the LFSR chooses victims and evictions happen often, while every returned word is compared against a memory model. Directed sequences reach cases that random traffic rarely hits: an empty set taking two tags, a non-allocating write miss, bypass invalidating on a write, a single enabled way thrashing, and parity faults injected both by a refill and by a write hit.

// File: rtl/cache2w_pkg.sv
// Shared types for the two-way write-through cache.
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } cache_state_e;
endpackage

// File: rtl/cache2w_lfsr.sv
// Free-running Galois LFSR used as the random victim source.
// Assumes a nonzero seed; the state then never reaches zero.
module cache2w_lfsr #(
    parameter int W = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // advance one step every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/cache2w_way.sv
// One way of the cache: valid bits, tag store with tag parity, data store
// with one parity bit per half word. Combinational read, one write port.
// Assumes inv and we never target the same set in one cycle.
module cache2w_way #(
    parameter int SET_BITS = 9,
    parameter int TAG_BITS = 12,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] rd_idx,
    input  logic [TAG_BITS-1:0] cmp_tag,
    output logic                rd_valid,
    output logic                rd_match,
    output logic                rd_bad,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                inv,
    input  logic                we,
    input  logic [SET_BITS-1:0] wr_idx,
    input  logic [TAG_BITS-1:0] wr_tag,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_flip
);
    localparam int SETS = 1 << SET_BITS;
    localparam int HALF = DATA_W / 2;

    logic [SETS-1:0]      vld;
    logic [TAG_BITS:0]    tag_mem [SETS];
    logic [DATA_W+1:0]    dat_mem [SETS];
    logic [TAG_BITS:0]    tag_e;
    logic [DATA_W+1:0]    dat_e;
    logic                 par_ok;

    // valid bits: set on write, cleared on invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (we)  vld[wr_idx] <= 1'b1;
            if (inv) vld[rd_idx] <= 1'b0;
        end
    end

    // tag and data stores with parity generated on write
    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[wr_idx] <= {^wr_tag, wr_tag};
            dat_mem[wr_idx] <= {^wr_data[DATA_W-1:HALF],
                                (^wr_data[HALF-1:0]) ^ wr_flip, wr_data};
        end
    end

    // lookup and parity check of the addressed entry
    always_comb begin
        tag_e    = tag_mem[rd_idx];
        dat_e    = dat_mem[rd_idx];
        rd_valid = vld[rd_idx];
        rd_match = rd_valid && (tag_e[TAG_BITS-1:0] == cmp_tag);
        par_ok   = (tag_e[TAG_BITS] == ^tag_e[TAG_BITS-1:0])
                && (dat_e[DATA_W+1] == ^dat_e[DATA_W-1:HALF])
                && (dat_e[DATA_W]   == ^dat_e[HALF-1:0]);
        rd_bad   = rd_match && !par_ok;
        rd_data  = dat_e[DATA_W-1:0];
    end

    p_write_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(inv && rd_idx == wr_idx)) |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/cache2w.sv
// Two-way set-associative write-through cache, one request at a time.
// Reads hit in one cycle; misses and all writes wait for mem_ack.
// Assumes mem_rdata is valid in the cycle mem_ack is high.
module cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SET_BITS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic              cfg_bypass,
    input  logic [1:0]        cfg_way_off,
    input  logic              flip_par,
    output logic              par_err,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int NWAY     = 2;
    localparam int TAG_BITS = ADDR_W - 1 - SET_BITS;

    cache_state_e          state;
    logic [ADDR_W-1:0]     q_addr;
    logic [DATA_W-1:0]     q_wdata;
    logic [NWAY-1:0]       q_victim;
    logic                  q_flip;
    logic [7:0]            rnd;

    logic [SET_BITS-1:0]   r_idx, w_idx;
    logic [TAG_BITS-1:0]   r_tag, w_tag;
    logic [DATA_W-1:0]     w_data;
    logic                  w_flip;
    logic                  accept, fill;
    logic [NWAY-1:0]       en, vld, match, bad, hit, we, inv, victim;
    logic [DATA_W-1:0]     way_data [NWAY];
    logic [DATA_W-1:0]     hit_data;

    assign r_idx  = req_addr[SET_BITS:1];
    assign r_tag  = req_addr[ADDR_W-1:SET_BITS+1];
    assign accept = (state == ST_IDLE) && req_valid;
    assign fill   = (state == ST_RD) && mem_ack;

    cache2w_lfsr i_rnd (.clk(clk), .rst_n(rst_n), .state(rnd));

    // write port source: memory data on refill, request data otherwise
    always_comb begin
        w_idx  = fill ? q_addr[SET_BITS:1] : r_idx;
        w_tag  = fill ? q_addr[ADDR_W-1:SET_BITS+1] : r_tag;
        w_data = fill ? mem_rdata : req_wdata;
        w_flip = fill ? q_flip : flip_par;
    end

    for (genvar w = 0; w < NWAY; w++) begin : g_way
        assign en[w]  = !cfg_bypass && !cfg_way_off[w];
        assign hit[w] = match[w] && !bad[w] && en[w];
        assign we[w]  = fill ? q_victim[w] : (accept && req_write && match[w] && en[w]);
        assign inv[w] = accept && match[w] && (req_write ? !en[w] : (bad[w] && en[w]));

        cache2w_way #(.SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS), .DATA_W(DATA_W)) i_way (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(r_idx), .cmp_tag(r_tag),
            .rd_valid(vld[w]), .rd_match(match[w]), .rd_bad(bad[w]), .rd_data(way_data[w]),
            .inv(inv[w]), .we(we[w]), .wr_idx(w_idx), .wr_tag(w_tag),
            .wr_data(w_data), .wr_flip(w_flip)
        );
    end

    // pick the hit way's word and the refill victim
    always_comb begin
        hit_data = hit[1] ? way_data[1] : way_data[0];
        if (bad[0] && en[0])           victim = 2'b01;
        else if (bad[1] && en[1])      victim = 2'b10;
        else if (en[0] && !vld[0])     victim = 2'b01;
        else if (en[1] && !vld[1])     victim = 2'b10;
        else if (en[0] && en[1])       victim = rnd[0] ? 2'b10 : 2'b01;
        else if (en[0])                victim = 2'b01;
        else if (en[1])                victim = 2'b10;
        else                           victim = 2'b00;
    end

    // control sequence: lookup, memory read or write, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            par_err    <= 1'b0;
            q_addr     <= '0;
            q_wdata    <= '0;
            q_victim   <= '0;
            q_flip     <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            par_err    <= accept && !req_write && |(bad & en);
            case (state)
                ST_IDLE: if (req_valid) begin
                    q_addr  <= {req_addr[ADDR_W-1:1], 1'b0};
                    q_wdata <= req_wdata;
                    q_flip  <= flip_par;
                    if (req_write) begin
                        state <= ST_WR;
                    end else if (|hit) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= hit_data;
                    end else begin
                        q_victim <= victim;
                        state    <= ST_RD;
                    end
                end
                ST_RD: if (mem_ack) begin
                    resp_valid <= 1'b1;
                    resp_rdata <= mem_rdata;
                    state      <= ST_IDLE;
                end
                ST_WR: if (mem_ack) begin
                    resp_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_req   = (state != ST_IDLE);
    assign mem_write = (state == ST_WR);
    assign mem_addr  = q_addr;
    assign mem_wdata = q_wdata;

    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (mem_req && mem_write && mem_wdata == $past(req_wdata)));
    p_miss_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && hit == '0) |=> (mem_req && !mem_write && !resp_valid));
    p_bypass_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && cfg_bypass) |=> mem_req);
    p_perr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> !par_err);
    p_perr_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (mem_req && !mem_write));
    p_addr_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);
endmodule

// File: tb/test_cache2w.sv
module test_cache2w;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_valid, par_err;
    logic [15:0] resp_rdata;
    logic        cfg_bypass = 0, flip_par = 0;
    logic [1:0]  cfg_way_off = 2'b00;
    logic        mem_req, mem_write, mem_ack = 0;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;

    int errors = 0, checks = 0;
    int rd_count = 0, wr_count = 0, pe_count = 0;
    logic [21:0] last_rd_addr, last_wr_addr;
    logic [15:0] last_wr_data;
    logic [15:0] mem_m [int];
    bit done = 0;

    cache2w i_cache2w (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .cfg_bypass(cfg_bypass),
        .cfg_way_off(cfg_way_off), .flip_par(flip_par), .par_err(par_err),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mval(input logic [21:0] a);
        int k = int'(a[21:1]);
        if (mem_m.exists(k)) return mem_m[k];
        return a[16:1] * 16'h9E37 ^ 16'h5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder: two cycles of latency, then a one-cycle ack
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    cnt = 0;
                    mem_ack = 1;
                    if (mem_write) begin
                        mem_m[int'(mem_addr[21:1])] = mem_wdata;
                        wr_count++; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
                    end else begin
                        mem_rdata = mval(mem_addr);
                        rd_count++; last_rd_addr = mem_addr;
                    end
                end
            end
        end
    end

    // parity pulse monitor: counts cycles with par_err high
    initial forever begin
        @(negedge clk);
        if (par_err) pe_count++;
    end

    task automatic do_req(input bit wr, input logic [21:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output int lat, output int nrd,
                          output int nwr, output int npe);
        int rd0 = rd_count, wr0 = wr_count, pe0 = pe_count;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; lat = 1;
        while (!resp_valid && lat < 50) begin @(negedge clk); lat++; end
        rd = resp_rdata;
        @(negedge clk);
        nrd = rd_count - rd0; nwr = wr_count - wr0; npe = pe_count - pe0;
    endtask

    task automatic rd_chk(input logic [21:0] a, input bit exp_hit, input int exp_pe,
                          input string req);
        logic [15:0] rd; int lat, nrd, nwr, npe;
        do_req(0, a, 16'h0, rd, lat, nrd, nwr, npe);
        chk(rd == mval(a), req, "read data", rd, mval(a));
        chk(nrd == (exp_hit ? 0 : 1), req, "memory reads", nrd, exp_hit ? 0 : 1);
        if (exp_hit) chk(lat == 1, req, "hit latency", lat, 1);
        else chk(last_rd_addr == {a[21:1], 1'b0}, req, "miss address", last_rd_addr, {a[21:1], 1'b0});
        chk(npe == exp_pe, req, "parity pulses", npe, exp_pe);
    endtask

    task automatic wr_chk(input logic [21:0] a, input logic [15:0] d, input string req);
        logic [15:0] rd; int lat, nrd, nwr, npe;
        do_req(1, a, d, rd, lat, nrd, nwr, npe);
        chk(nwr == 1 && nrd == 0, req, "write count", nwr, 1);
        chk(last_wr_addr == {a[21:1], 1'b0} && last_wr_data == d, req, "write addr/data",
            last_wr_data, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [21:0] a, b, c, dd;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(req_ready && !resp_valid && !par_err && !mem_req, "R10", "reset outputs",
            {req_ready, resp_valid, par_err, mem_req}, 4'b1000);

        // R3, R1, R2: fill then hit, bit 0 ignored
        a = 22'h012468;
        rd_chk(a, 0, 0, "R3");
        rd_chk(a | 22'h1, 1, 0, "R1");
        rd_chk(a, 1, 0, "R2");

        // R4: second tag in same set goes to the empty way, both stay
        b = a ^ 22'h000400;
        rd_chk(b, 0, 0, "R4");
        rd_chk(a, 1, 0, "R4");
        rd_chk(b, 1, 0, "R4");

        // R6: write miss no allocate, write hit updates
        c = 22'h000222;
        wr_chk(c, 16'hBEEF, "R5");
        rd_chk(c, 0, 0, "R6");
        wr_chk(a, 16'h1357, "R6");
        rd_chk(a, 1, 0, "R6");

        // R8: bypass forces misses, write invalidates
        cfg_bypass = 1;
        rd_chk(a, 0, 0, "R8");
        rd_chk(a, 0, 0, "R8");
        wr_chk(a, 16'h2468, "R8");
        cfg_bypass = 0;
        rd_chk(a, 0, 0, "R8");
        rd_chk(b, 1, 0, "R8");

        // R9: way 0 off, two tags evict each other in way 1
        cfg_way_off = 2'b01;
        c = 22'h0008A0; dd = c ^ 22'h000C00;
        rd_chk(c, 0, 0, "R9");
        rd_chk(dd, 0, 0, "R9");
        rd_chk(c, 0, 0, "R9");
        cfg_way_off = 2'b00;

        // R11, R7: injected parity fault on refill, then on write hit
        dd = 22'h0031F0;
        flip_par = 1;
        rd_chk(dd, 0, 0, "R11");
        flip_par = 0;
        rd_chk(dd, 0, 1, "R7");
        rd_chk(dd, 1, 0, "R7");
        flip_par = 1;
        wr_chk(dd, 16'h0F0F, "R11");
        flip_par = 0;
        rd_chk(dd, 0, 1, "R11");
        rd_chk(dd, 1, 0, "R7");

        // random traffic over four sets and four tags
        for (int i = 0; i < 1500; i++) begin
            logic [21:0] ra;
            logic [15:0] rd; int lat, nrd, nwr, npe;
            bit wr;
            ra = {$urandom_range(3, 0) == 0 ? 12'h0 : 12'(($urandom_range(3, 0)) * 12'h155),
                  9'(5 + $urandom_range(3, 0) * 100), 1'($urandom_range(1, 0))};
            wr = ($urandom_range(3, 0) == 0);
            if (wr) begin
                logic [15:0] wd = 16'($urandom);
                do_req(1, ra, wd, rd, lat, nrd, nwr, npe);
                chk(nwr == 1 && last_wr_addr == {ra[21:1], 1'b0} && last_wr_data == wd,
                    "R5", "random write-through", last_wr_data, wd);
            end else begin
                do_req(0, ra, 16'h0, rd, lat, nrd, nwr, npe);
                chk(rd == mval(ra), "R3", "random read data", rd, mval(ra));
                chk((nrd == 0 && lat == 1) || (nrd == 1 && last_rd_addr == {ra[21:1], 1'b0}),
                    "R2", "random hit/miss shape", nrd, 0);
                rd_chk(ra, 1, 0, "R3");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule